// File: doc/BRIEF.md
# Stream-to-AXI Burst-Coalescing Bridge

The bridge sits between user logic that speaks in single memory words and an AXI4 master port. User logic pushes one 64-bit byte address per word on a read-address stream or a write-address stream, plus one data word per write on a write-data stream. The bridge watches those address streams as they arrive. When each new address lies exactly one word above the previous one, it appends that address to an open burst. Otherwise it closes the burst and issues it on the AR or AW channel as a single INCR transaction. Random addresses that cannot be merged still go out as independent single-beat transactions, and many of them can be outstanding at once.

All traffic uses one AXI ID, so read beats come back in issue order. They are forwarded straight to the read-data stream with no burst buffer. On the write side, a small FIFO of burst lengths serves two purposes. It lets the bridge frame the write-data beats with WLAST, and it converts each B response into a completion count on an 8-bit response stream. A burst that stays open with no new address is flushed after a fixed number of idle cycles, which keeps latency bounded.

Top module: `stream_axi_coalescer`

## Requirements
- R1: Read-data words leave on the read-data stream in the order their addresses were accepted, each carrying the memory word at that address. Read-data valid equals RVALID in every cycle, so no burst is held on chip.
- R2: Addresses accepted back to back, where each is exactly DATA_W/8 bytes above the previous, form one burst. AxADDR is the first address and AxLEN is the beat count minus one. This holds for both reads and writes.
- R3: An address that is not one word above the previous closes the open burst. A stream of non-adjacent addresses gives one single-beat burst per address (AxLEN 0), and a new AR is issued while earlier read bursts are still waiting for data.
- R4: No burst crosses a 4096-byte boundary. An address whose low 12 bits are zero always starts a new burst.
- R5: No burst holds more than MAX_BEATS beats. The next adjacent address after a full burst starts a new one.
- R6: An open burst is issued once IDLE_LIM cycles pass with no valid address. With the default 16, ARVALID first rises 17 clock edges after the edge that accepted the last address.
- R7: Write-data words go out on W in the order of their write addresses. WLAST is high exactly on the final beat of each burst. W carries no beat before the AW of its burst has been accepted. Memory ends up holding the last value written to each address.
- R8: Each B response yields one write-response value, in order, equal to the number of beats in that write burst minus one (0 means one write completed). The value stays stable while it is not accepted.
- R9: In the cycle after reset, ARVALID, AWVALID and the write-response valid are low, and both address streams are ready.
- R10: Once ARVALID or AWVALID is high, it stays high with an unchanged address and length until the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_valid | input | 1 | Read-address stream valid |
| rd_addr_ready | output | 1 | Read-address stream ready |
| rd_addr | input | 64 | Byte address of one word to read |
| rd_data_valid | output | 1 | Read-data stream valid |
| rd_data_ready | input | 1 | Read-data stream ready |
| rd_data | output | DATA_W | Read word |
| wr_addr_valid | input | 1 | Write-address stream valid |
| wr_addr_ready | output | 1 | Write-address stream ready |
| wr_addr | input | 64 | Byte address of one word to write |
| wr_data_valid | input | 1 | Write-data stream valid |
| wr_data_ready | output | 1 | Write-data stream ready |
| wr_data | input | DATA_W | Word to write |
| wr_resp_valid | output | 1 | Write-response stream valid |
| wr_resp_ready | input | 1 | Write-response stream ready |
| wr_resp | output | 8 | Completed writes minus one |
| m_araddr | output | 64 | AR address |
| m_arlen | output | 8 | AR beats minus one |
| m_arvalid | output | 1 | AR valid |
| m_arready | input | 1 | AR ready |
| m_rdata | input | DATA_W | R data |
| m_rvalid | input | 1 | R valid |
| m_rready | output | 1 | R ready |
| m_awaddr | output | 64 | AW address |
| m_awlen | output | 8 | AW beats minus one |
| m_awvalid | output | 1 | AW valid |
| m_awready | input | 1 | AW ready |
| m_wdata | output | DATA_W | W data |
| m_wlast | output | 1 | Last beat of a write burst |
| m_wvalid | output | 1 | W valid |
| m_wready | input | 1 | W ready |
| m_bvalid | input | 1 | B valid |
| m_bready | output | 1 | B ready |

## Verification
The assertions check, on every cycle, that no issued burst runs past a 4 KB page and that AR, AW and the response value hold steady under back-pressure. They also check that W never leads the AW it belongs to and that the reset state is clean. Whether runs are split at the right addresses, whether read words return in order with the correct contents, the exact flush delay, and the mapping of B responses to completion counts can only be shown by the bench. It does this by comparing the logged bursts, data and responses against a plan computed from the address sequences.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int ADDR_W   = 64;
  localparam int AXLEN_W  = 8;
  localparam int RESP_W   = 8;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/sac_len_fifo.sv
module sac_len_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout  = mem[rp_q[AW-1:0]];

  // storage has no reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push && !full) wp_q <= wp_q + (AW+1)'(1);
      if (pop && !empty) rp_q <= rp_q + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/sac_burst_merge.sv
module sac_burst_merge
  import sac_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 256,
  parameter int IDLE_LIM  = 16,
  parameter int PAGE_BITS = 12,
  parameter int LEN_W     = $clog2(MAX_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  addr_t            in_addr,
  output logic             out_valid,
  input  logic             out_ready,
  output addr_t            out_addr,
  output logic [LEN_W-1:0] out_len
);
  localparam addr_t WORD_BYTES = addr_t'(DATA_W / 8);
  localparam int    IDLE_W     = $clog2(IDLE_LIM + 1);

  logic             open_q;
  addr_t            start_q;
  addr_t            next_q;
  logic [LEN_W-1:0] cnt_q;
  logic [IDLE_W-1:0] idle_q;

  logic slot_free, can_extend, take, flush;

  always_comb begin
    slot_free  = !out_valid || out_ready;
    can_extend = open_q && (in_addr == next_q) &&
                 (cnt_q < LEN_W'(MAX_BEATS)) &&
                 (next_q[PAGE_BITS-1:0] != '0);
    in_ready   = !open_q || can_extend || slot_free;
    take       = in_valid && in_ready;
    flush      = open_q && !in_valid && (idle_q == IDLE_W'(IDLE_LIM)) && slot_free;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= 1'b0;
      start_q   <= '0;
      next_q    <= '0;
      cnt_q     <= '0;
      idle_q    <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_len   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        idle_q <= '0;
        if (can_extend) begin
          cnt_q  <= cnt_q + LEN_W'(1);
          next_q <= next_q + WORD_BYTES;
        end else begin
          if (open_q) begin
            out_valid <= 1'b1;
            out_addr  <= start_q;
            out_len   <= cnt_q;
          end
          open_q  <= 1'b1;
          start_q <= in_addr;
          next_q  <= in_addr + WORD_BYTES;
          cnt_q   <= LEN_W'(1);
        end
      end else if (flush) begin
        out_valid <= 1'b1;
        out_addr  <= start_q;
        out_len   <= cnt_q;
        open_q    <= 1'b0;
        idle_q    <= '0;
      end else if (open_q && !in_valid && (idle_q != IDLE_W'(IDLE_LIM))) begin
        idle_q <= idle_q + IDLE_W'(1);
      end
    end
  end
endmodule

// File: rtl/sac_wr_seq.sv
module sac_wr_seq
  import sac_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 9,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aw_fire,
  input  logic [LEN_W-1:0]  aw_len,
  output logic              len_full,
  input  logic              wr_data_valid,
  output logic              wr_data_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              wr_resp_valid,
  input  logic              wr_resp_ready,
  output logic [RESP_W-1:0] wr_resp
);
  // index 0 frames W beats, index 1 converts B responses to counts
  logic [1:0]       pop_v, full_v, empty_v;
  logic [LEN_W-1:0] head [2];
  logic [LEN_W-1:0] beat_q;

  for (genvar g = 0; g < 2; g++) begin : g_len
    sac_len_fifo #(.W(LEN_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (aw_fire),
      .din   (aw_len),
      .pop   (pop_v[g]),
      .dout  (head[g]),
      .full  (full_v[g]),
      .empty (empty_v[g])
    );
  end

  assign len_full      = |full_v;
  assign m_wvalid      = wr_data_valid && !empty_v[0];
  assign wr_data_ready = m_wready && !empty_v[0];
  assign m_wdata       = wr_data;
  assign m_wlast       = (beat_q == head[0] - LEN_W'(1));
  assign pop_v[0]      = m_wvalid && m_wready && m_wlast;
  assign m_bready      = !wr_resp_valid || wr_resp_ready;
  assign pop_v[1]      = m_bvalid && m_bready;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (m_wvalid && m_wready) begin
      beat_q <= m_wlast ? '0 : beat_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_resp_valid <= 1'b0;
      wr_resp       <= '0;
    end else if (pop_v[1]) begin
      wr_resp_valid <= 1'b1;
      wr_resp       <= RESP_W'(head[1] - LEN_W'(1));
    end else if (wr_resp_ready) begin
      wr_resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stream_axi_coalescer.sv
module stream_axi_coalescer
  import sac_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int MAX_BEATS      = 256,
  parameter int IDLE_LIM       = 16,
  parameter int LEN_FIFO_DEPTH = 8,
  parameter int PAGE_BITS      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_addr_valid,
  output logic              rd_addr_ready,
  input  logic [63:0]       rd_addr,
  output logic              rd_data_valid,
  input  logic              rd_data_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_addr_valid,
  output logic              wr_addr_ready,
  input  logic [63:0]       wr_addr,
  input  logic              wr_data_valid,
  output logic              wr_data_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_resp_valid,
  input  logic              wr_resp_ready,
  output logic [7:0]        wr_resp,
  output logic [63:0]       m_araddr,
  output logic [7:0]        m_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [63:0]       m_awaddr,
  output logic [7:0]        m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic              m_bvalid,
  output logic              m_bready
);
  localparam int LEN_W = $clog2(MAX_BEATS + 1);

  logic [LEN_W-1:0] ar_len, aw_len;
  logic             aw_pend, aw_take, len_full, aw_fire;

  sac_burst_merge #(
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .IDLE_LIM(IDLE_LIM),
    .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)
  ) u_rd_merge (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rd_addr_valid),
    .in_ready  (rd_addr_ready),
    .in_addr   (rd_addr),
    .out_valid (m_arvalid),
    .out_ready (m_arready),
    .out_addr  (m_araddr),
    .out_len   (ar_len)
  );

  assign m_arlen       = AXLEN_W'(ar_len - LEN_W'(1));
  // single ID: beats arrive in issue order and go straight out
  assign rd_data_valid = m_rvalid;
  assign rd_data       = m_rdata;
  assign m_rready      = rd_data_ready;

  sac_burst_merge #(
    .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .IDLE_LIM(IDLE_LIM),
    .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)
  ) u_wr_merge (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (wr_addr_valid),
    .in_ready  (wr_addr_ready),
    .in_addr   (wr_addr),
    .out_valid (aw_pend),
    .out_ready (aw_take),
    .out_addr  (m_awaddr),
    .out_len   (aw_len)
  );

  assign m_awvalid = aw_pend && !len_full;
  assign aw_take   = m_awready && !len_full;
  assign aw_fire   = m_awvalid && m_awready;
  assign m_awlen   = AXLEN_W'(aw_len - LEN_W'(1));

  sac_wr_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .FIFO_DEPTH(LEN_FIFO_DEPTH)) u_wr_seq (
    .clk           (clk),
    .rst           (rst),
    .aw_fire       (aw_fire),
    .aw_len        (aw_len),
    .len_full      (len_full),
    .wr_data_valid (wr_data_valid),
    .wr_data_ready (wr_data_ready),
    .wr_data       (wr_data),
    .m_wdata       (m_wdata),
    .m_wlast       (m_wlast),
    .m_wvalid      (m_wvalid),
    .m_wready      (m_wready),
    .m_bvalid      (m_bvalid),
    .m_bready      (m_bready),
    .wr_resp_valid (wr_resp_valid),
    .wr_resp_ready (wr_resp_ready),
    .wr_resp       (wr_resp)
  );
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        m_arvalid,
  input logic        m_arready,
  input logic [63:0] m_araddr,
  input logic [7:0]  m_arlen,
  input logic        m_awvalid,
  input logic        m_awready,
  input logic [63:0] m_awaddr,
  input logic [7:0]  m_awlen,
  input logic        m_wvalid,
  input logic        m_wready,
  input logic        m_wlast,
  input logic        wr_resp_valid,
  input logic        wr_resp_ready,
  input logic [7:0]  wr_resp
);
  localparam int WB   = DATA_W / 8;
  localparam int PAGE = 1 << PAGE_BITS;

  logic [15:0] aw_open_q;
  always_ff @(posedge clk) begin
    if (rst) aw_open_q <= '0;
    else aw_open_q <= aw_open_q + 16'(m_awvalid && m_awready)
                                - 16'(m_wvalid && m_wready && m_wlast);
  end

  p_ar_page_r4: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> (int'(m_araddr[PAGE_BITS-1:0]) + (int'(m_arlen) + 1) * WB) <= PAGE);
  p_aw_page_r4: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> (int'(m_awaddr[PAGE_BITS-1:0]) + (int'(m_awlen) + 1) * WB) <= PAGE);
  p_ar_hold_r10: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));
  p_aw_hold_r10: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));
  p_resp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    wr_resp_valid && !wr_resp_ready |=> wr_resp_valid && $stable(wr_resp));
  p_w_after_aw_r7: assert property (@(posedge clk) disable iff (rst)
    m_wvalid |-> aw_open_q != 16'd0);
  p_reset_idle_r9: assert property (@(posedge clk)
    $past(rst) |-> !m_arvalid && !m_awvalid && !wr_resp_valid);
endmodule

bind stream_axi_coalescer sac_checker #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .m_arvalid     (m_arvalid),
  .m_arready     (m_arready),
  .m_araddr      (m_araddr),
  .m_arlen       (m_arlen),
  .m_awvalid     (m_awvalid),
  .m_awready     (m_awready),
  .m_awaddr      (m_awaddr),
  .m_awlen       (m_awlen),
  .m_wvalid      (m_wvalid),
  .m_wready      (m_wready),
  .m_wlast       (m_wlast),
  .wr_resp_valid (wr_resp_valid),
  .wr_resp_ready (wr_resp_ready),
  .wr_resp       (wr_resp)
);

// File: tb/sim_stream_axi_coalescer.sv
`timescale 1ns/1ps
module sim_stream_axi_coalescer;
  localparam int DW   = 32;
  localparam int MAXB = 256;
  localparam int IDLE = 16;

  typedef struct { longint unsigned addr; int len; } bst_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          rd_addr_valid = 0, rd_addr_ready;
  logic [63:0]   rd_addr = '0;
  logic          rd_data_valid, rd_data_ready = 0;
  logic [DW-1:0] rd_data;
  logic          wr_addr_valid = 0, wr_addr_ready;
  logic [63:0]   wr_addr = '0;
  logic          wr_data_valid = 0, wr_data_ready;
  logic [DW-1:0] wr_data = '0;
  logic          wr_resp_valid, wr_resp_ready = 0;
  logic [7:0]    wr_resp;
  logic [63:0]   m_araddr, m_awaddr;
  logic [7:0]    m_arlen, m_awlen;
  logic          m_arvalid, m_arready = 0;
  logic [DW-1:0] m_rdata = '0;
  logic          m_rvalid = 0, m_rready;
  logic          m_awvalid, m_awready = 0;
  logic [DW-1:0] m_wdata;
  logic          m_wlast, m_wvalid, m_wready = 0;
  logic          m_bvalid = 0, m_bready;

  stream_axi_coalescer #(.DATA_W(DW), .MAX_BEATS(MAXB), .IDLE_LIM(IDLE)) u0 (.*);

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [4096];
  logic [DW-1:0] exp_mem [4096];
  bst_t ar_log[$], aw_log[$], arq[$], awq[$], exp_b[$];
  logic [DW-1:0] rcv[$];
  logic [7:0] resp_log[$];
  longint unsigned addr_q[$], wa_q[$];
  logic [DW-1:0] wd_q[$];
  int rbeat = 0, wbeat = 0, bpend = 0, max_out = 0, pass_err = 0, wlast_err = 0;

  function automatic int widx(input longint unsigned a);
    return int'((a >> 2) & 64'd4095);
  endfunction

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i) * 32'h9E3779B1 + 32'h1234;
  endfunction

  // expected burst split from the merge rules (R2 R3 R4 R5)
  function automatic void build_plan();
    longint unsigned nxt = 0;
    bit open = 0;
    exp_b.delete();
    foreach (addr_q[i]) begin
      if (open && addr_q[i] == nxt && exp_b[$].len < MAXB && nxt[11:0] != 12'd0) begin
        exp_b[$].len++;
      end else begin
        exp_b.push_back('{addr_q[i], 1});
        open = 1;
      end
      nxt = addr_q[i] + 4;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_bursts(input string req, input bst_t got[$]);
    int bad = -1;
    chk(got.size() == exp_b.size(), req, "burst count", got.size(), exp_b.size());
    foreach (exp_b[i])
      if (bad < 0 && (i >= got.size() || got[i].addr != exp_b[i].addr || got[i].len != exp_b[i].len))
        bad = i;
    chk(bad < 0, req, "first burst mismatch index", bad, -1);
  endtask

  // AXI slave model and stream sinks
  always @(posedge clk) begin
    if (rst) begin
      arq.delete(); awq.delete(); rbeat = 0; wbeat = 0; bpend = 0;
      m_arready <= 0; m_rvalid <= 0; m_awready <= 0; m_wready <= 0; m_bvalid <= 0;
      rd_data_ready <= 0; wr_resp_ready <= 0;
    end else begin
      if (rd_data_valid != m_rvalid) pass_err++;
      if (m_rvalid && m_rready) begin
        rbeat++;
        if (rbeat == arq[0].len) begin void'(arq.pop_front()); rbeat = 0; end
      end
      if (rd_data_valid && rd_data_ready) rcv.push_back(rd_data);
      if (m_arvalid && m_arready) begin
        arq.push_back('{m_araddr, int'(m_arlen) + 1});
        ar_log.push_back('{m_araddr, int'(m_arlen) + 1});
        if (arq.size() > max_out) max_out = arq.size();
      end
      if (m_awvalid && m_awready) begin
        awq.push_back('{m_awaddr, int'(m_awlen) + 1});
        aw_log.push_back('{m_awaddr, int'(m_awlen) + 1});
      end
      if (m_wvalid && m_wready) begin
        bit last_exp;
        if (awq.size() == 0) wlast_err++;
        else begin
          mem[widx(awq[0].addr + 64'(wbeat * 4))] = m_wdata;
          wbeat++;
          last_exp = (wbeat == awq[0].len);
          if (m_wlast != last_exp) wlast_err++;
          if (last_exp) begin void'(awq.pop_front()); wbeat = 0; bpend++; end
        end
      end
      if (m_bvalid && m_bready) bpend--;
      if (wr_resp_valid && wr_resp_ready) resp_log.push_back(wr_resp);

      m_arready     <= ($urandom % 4) != 0;
      m_awready     <= ($urandom % 4) != 0;
      m_wready      <= ($urandom % 4) != 0;
      rd_data_ready <= ($urandom % 4) != 0;
      wr_resp_ready <= ($urandom % 3) != 0;
      if (!(m_rvalid && !m_rready)) begin
        if (arq.size() > 0 && ($urandom % 3) != 0) begin
          m_rvalid <= 1;
          m_rdata  <= mem[widx(arq[0].addr + 64'(rbeat * 4))];
        end else m_rvalid <= 0;
      end
      if (!(m_bvalid && !m_bready)) m_bvalid <= (bpend > 0) && ($urandom % 2 == 0);
    end
  end

  task automatic drive_rd();
    foreach (addr_q[i]) begin
      rd_addr_valid <= 1;
      rd_addr <= addr_q[i];
      @(posedge clk);
      while (!rd_addr_ready) @(posedge clk);
    end
    rd_addr_valid <= 0;
  endtask

  task automatic drive_wa();
    foreach (wa_q[i]) begin
      wr_addr_valid <= 1;
      wr_addr <= wa_q[i];
      @(posedge clk);
      while (!wr_addr_ready) @(posedge clk);
    end
    wr_addr_valid <= 0;
  endtask

  task automatic drive_wd();
    foreach (wd_q[i]) begin
      wr_data_valid <= 1;
      wr_data <= wd_q[i];
      @(posedge clk);
      while (!wr_data_ready) @(posedge clk);
    end
    wr_data_valid <= 0;
  endtask

  task automatic run_read(input string req);
    int bad = -1;
    ar_log.delete(); rcv.delete(); max_out = 0;
    build_plan();
    drive_rd();
    while (rcv.size() < addr_q.size()) @(negedge clk);
    cmp_bursts(req, ar_log);
    foreach (addr_q[i])
      if (bad < 0 && rcv[i] != mem[widx(addr_q[i])]) bad = i;
    chk(bad < 0, "R1", "first read word out of order or wrong, index", bad, -1);
  endtask

  task automatic run_write(input string req);
    int sum = 0, bad = -1;
    aw_log.delete(); resp_log.delete();
    addr_q = wa_q;
    build_plan();
    wd_q.delete();
    foreach (wa_q[i]) begin
      wd_q.push_back($urandom);
      exp_mem[widx(wa_q[i])] = wd_q[i];
    end
    fork
      drive_wa();
      drive_wd();
    join
    while (sum < wa_q.size()) begin
      @(negedge clk);
      sum = 0;
      foreach (resp_log[i]) sum += int'(resp_log[i]) + 1;
    end
    cmp_bursts(req, aw_log);
    chk(resp_log.size() == exp_b.size(), "R8", "response count", resp_log.size(), exp_b.size());
    foreach (exp_b[i])
      if (bad < 0 && (i >= resp_log.size() || int'(resp_log[i]) != exp_b[i].len - 1)) bad = i;
    chk(bad < 0, "R8", "first response value mismatch index", bad, -1);
    bad = -1;
    for (int i = 2048; i < 4096; i++) if (bad < 0 && mem[i] != exp_mem[i]) bad = i;
    chk(bad < 0, "R7", "first memory word mismatch", bad, -1);
  endtask

  task automatic fill_mixed(input int base, input int span, input int n, ref longint unsigned q[$]);
    int cur = base + int'($urandom % span);
    q.delete();
    for (int i = 0; i < n; i++) begin
      if ($urandom % 3 == 0) cur = base + int'($urandom % span);
      else begin
        cur++;
        if (cur >= base + span) cur = base;
      end
      q.push_back(64'(cur) * 4);
    end
  endtask

  task automatic run_all();
    int k;
    repeat (5) @(posedge clk);
    rst <= 0;
    @(negedge clk);
    chk(!m_arvalid && !m_awvalid && !wr_resp_valid, "R9", "valids after reset",
        {m_arvalid, m_awvalid, wr_resp_valid}, 0);
    chk(rd_addr_ready && wr_addr_ready, "R9", "address streams ready", {rd_addr_ready, wr_addr_ready}, 3);

    addr_q.delete();
    for (int i = 0; i < 8; i++) addr_q.push_back(64'h200 + 64'(i * 4));
    run_read("R2");
    chk(ar_log.size() > 0 && ar_log[0].len == 8, "R2", "eight adjacent words one burst",
        ar_log.size() > 0 ? ar_log[0].len : 0, 8);

    addr_q = '{64'd4088, 64'd4092, 64'd4096, 64'd4100, 64'd4104};
    run_read("R4");

    addr_q.delete();
    for (int i = 0; i < 300; i++) addr_q.push_back(64'(i * 4));
    run_read("R5");
    chk(ar_log.size() == 2 && ar_log[0].len == MAXB, "R5", "first burst capped",
        ar_log.size() > 0 ? ar_log[0].len : 0, MAXB);

    addr_q.delete();
    for (int i = 0; i < 20; i++) addr_q.push_back(64'(i * 7 + int'($urandom % 3)) * 4);
    run_read("R3");
    chk(max_out >= 2, "R3", "outstanding read bursts", max_out, 2);

    fill_mixed(0, 2048, 60, addr_q);
    run_read("R2");

    addr_q = '{64'h300, 64'h304, 64'h308};
    ar_log.delete(); rcv.delete();
    drive_rd();
    k = 0;
    do begin @(negedge clk); k++; end while (!m_arvalid && k < 200);
    chk(k == IDLE + 2, "R6", "negedges until flushed ARVALID", k, IDLE + 2);
    while (rcv.size() < 3) @(negedge clk);
    chk(ar_log.size() == 1 && ar_log[0].len == 3, "R6", "flushed burst length",
        ar_log.size() > 0 ? ar_log[0].len : 0, 3);

    wa_q.delete();
    for (int i = 0; i < 20; i++) wa_q.push_back(64'd8192 + 64'(i * 4));
    run_write("R2");

    fill_mixed(2048, 2048, 40, wa_q);
    run_write("R7");

    wa_q = '{64'd12280, 64'd12284, 64'd12288, 64'd12292};
    run_write("R4");

    chk(pass_err == 0, "R1", "cycles where read-data valid differs from RVALID", pass_err, 0);
    chk(wlast_err == 0, "R7", "WLAST or W-before-AW errors", wlast_err, 0);
  endtask

  initial begin
    bit timed_out = 0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = init_word(i);
      exp_mem[i] = init_word(i);
    end
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timed_out = 1; end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule